// File: doc/BRIEF.md
# SPI Memory Address-Width Probe

This block is an SPI master that reads from a single serial EEPROM or flash whose address length is not known in advance. After a start pulse it lowers its chip select and sends a read command. It then clocks out zero bytes one at a time and watches what the memory returns. While the memory is still taking in address bytes, its output line is pulled up and every returned byte is all ones. The first byte that differs from all ones is taken as the contents of location zero. The number of zero bytes the memory consumed before that byte gives the address width, which is reported as a byte count from 1 to 4.

Once the width is known, the chip select stays low. Each later transfer reads the next sequential location and delivers it on a valid/ready byte stream. A consumer that holds ready low stops the serial clock between bytes. If no such byte has appeared after the largest supported number of address bytes, the block raises an error flag and releases the chip select.

The serial clock comes from a divider in the system clock domain. Each SCLK phase lasts a programmable number of system clocks, 0x85 by default.

Top module: `spi_addr_probe`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sclk` is 0, and `det_valid`, `probe_err` and `out_valid` are all 0.
- R2: A `start` pulse in the idle state lowers `spi_cs_n`, and the first byte on `spi_mosi` is the read command 0x03. Bytes are sent MSB first in SPI mode 0: SCLK idles low, data changes on the falling edge and is sampled on the rising edge.
- R3: Every byte sent on `spi_mosi` after the command is 0x00, during both probing and streaming.
- R4: Transfer n after the command, counted from 1, reads one byte. The first such transfer with n ≥ 2 whose received byte is not 0xFF sets `det_valid` to 1 and sets `det_bytes` to n−1. For a memory that takes W address bytes, W is in 1..4.
- R5: If transfers 2 through 5 all return 0xFF, `probe_err` goes to 1 and `spi_cs_n` returns to 1 with `det_valid` still 0. Exactly five zero bytes follow the command in this case.
- R6: The byte that ended probing is the first byte on the output stream. Each later stream byte is the next sequential memory location. A byte is transferred when `out_valid` and `out_ready` are both 1.
- R7: While `out_valid` is 1 and `out_ready` is 0, `spi_sclk` stays 0, and `out_data` and `out_valid` hold their values.
- R8: Each high phase of `spi_sclk` lasts exactly CLK_DIV system clock cycles. Each low phase inside a byte also lasts CLK_DIV cycles.
- R9: Once `det_valid` is 1, `spi_cs_n` stays 0 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a probe; has effect only when idle |
| spi_cs_n | output | 1 | Memory chip select, active low |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the memory |
| spi_miso | input | 1 | Serial data from the memory (pulled up) |
| det_valid | output | 1 | Address width has been found |
| det_bytes | output | CNT_W (3) | Detected number of address bytes, 1..ADDR_MAX |
| probe_err | output | 1 | No valid byte after ADDR_MAX address bytes |
| out_valid | output | 1 | Stream byte available |
| out_data | output | 8 | Stream byte |
| out_ready | input | 1 | Consumer accepts the stream byte |

## Verification
The bench builds the block with CLK_DIV = 3 and the default ADDR_MAX = 4. The short divider keeps each serial byte to roughly fifty system clocks. That is short enough for the run to cover all four address widths, the exhausted-probe case and a long consumer stall, and the exact phase length can still be measured against the parameter. The bench models the memory at the pin level, returning all ones until it has received its configured number of address bytes, so both the width decision and the sequential data ordering are checked from the wires.

// File: rtl/spi_probe_pkg.sv
package spi_probe_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_PROBE,
    ST_HOLD,
    ST_STREAM
  } probe_st_e;

  localparam logic [7:0] FILL_BYTE = 8'h00;
  localparam logic [7:0] IDLE_LINE = 8'hFF;

  // A returned byte counts as data when the pulled-up line was driven.
  function automatic logic byte_is_data(input logic [7:0] b);
    return b != IDLE_LINE;
  endfunction

  // Transfer n after the command reads what follows n-1 address bytes.
  function automatic int unsigned width_of_xfer(input int unsigned n);
    return n - 1;
  endfunction

endpackage

// File: rtl/spi_tick_gen.sv
module spi_tick_gen #(
  parameter int DIV_W = 8,
  parameter int DIV   = 133
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int DIV_EFF = (DIV < 1) ? 1 : DIV;

  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == DIV_W'(DIV_EFF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/spi_byte_xfer.sv
module spi_byte_xfer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] tx_byte,
  input  logic       tick,
  input  logic       miso,
  output logic       active,
  output logic       sclk,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx_byte
);
  logic [7:0] sh;
  logic [2:0] bit_idx;

  assign mosi = sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      sclk    <= 1'b0;
      sh      <= '0;
      bit_idx <= '0;
      rx_byte <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go && !active) begin
        active  <= 1'b1;
        sh      <= tx_byte;
        bit_idx <= '0;
        sclk    <= 1'b0;
      end else if (active && tick) begin
        if (!sclk) begin
          sclk    <= 1'b1;
          rx_byte <= {rx_byte[6:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bit_idx == 3'd7) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            bit_idx <= bit_idx + 1'b1;
            sh      <= {sh[6:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_addr_probe.sv
module spi_addr_probe
  import spi_probe_pkg::*;
#(
  parameter int          DIV_W    = 8,
  parameter int          CLK_DIV  = 133,
  parameter int          ADDR_MAX = 4,
  parameter logic [7:0]  READ_CMD = 8'h03,
  localparam int         CNT_W    = $clog2(ADDR_MAX + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             spi_cs_n,
  output logic             spi_sclk,
  output logic             spi_mosi,
  input  logic             spi_miso,
  output logic             det_valid,
  output logic [CNT_W-1:0] det_bytes,
  output logic             probe_err,
  output logic             out_valid,
  output logic [7:0]       out_data,
  input  logic             out_ready
);
  localparam int XFER_LAST = ADDR_MAX + 1;

  probe_st_e        state;
  logic [CNT_W-1:0] xfer_cnt;
  logic             go_q;
  logic [7:0]       tx_q;
  logic             tick;
  logic             eng_active;
  logic             byte_done;
  logic [7:0]       rx_byte;

  // Named internal events.
  logic [CNT_W-1:0] xfer_next;
  logic             probe_hit;
  logic             probe_exhaust;
  logic             stream_take;

  assign xfer_next     = xfer_cnt + 1'b1;
  assign probe_hit     = (state == ST_PROBE) && byte_done &&
                         (int'(xfer_next) >= 2) && byte_is_data(rx_byte);
  assign probe_exhaust = (state == ST_PROBE) && byte_done && !probe_hit &&
                         (int'(xfer_next) == XFER_LAST);
  assign stream_take   = (state == ST_HOLD) && out_ready;

  spi_tick_gen #(.DIV_W(DIV_W), .DIV(CLK_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (eng_active),
    .tick (tick)
  );

  spi_byte_xfer u_xfer (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (go_q),
    .tx_byte(tx_q),
    .tick   (tick),
    .miso   (spi_miso),
    .active (eng_active),
    .sclk   (spi_sclk),
    .mosi   (spi_mosi),
    .done   (byte_done),
    .rx_byte(rx_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      xfer_cnt  <= '0;
      go_q      <= 1'b0;
      tx_q      <= FILL_BYTE;
      spi_cs_n  <= 1'b1;
      det_valid <= 1'b0;
      det_bytes <= '0;
      probe_err <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      go_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            spi_cs_n  <= 1'b0;
            probe_err <= 1'b0;
            xfer_cnt  <= '0;
            tx_q      <= READ_CMD;
            go_q      <= 1'b1;
            state     <= ST_CMD;
          end
        end
        ST_CMD: begin
          if (byte_done) begin
            tx_q  <= FILL_BYTE;
            go_q  <= 1'b1;
            state <= ST_PROBE;
          end
        end
        ST_PROBE: begin
          if (byte_done) begin
            xfer_cnt <= xfer_next;
            if (probe_hit) begin
              det_valid <= 1'b1;
              det_bytes <= CNT_W'(width_of_xfer(int'(xfer_next)));
              out_valid <= 1'b1;
              out_data  <= rx_byte;
              state     <= ST_HOLD;
            end else if (probe_exhaust) begin
              probe_err <= 1'b1;
              spi_cs_n  <= 1'b1;
              state     <= ST_IDLE;
            end else begin
              go_q <= 1'b1;
            end
          end
        end
        ST_HOLD: begin
          if (stream_take) begin
            out_valid <= 1'b0;
            go_q      <= 1'b1;
            state     <= ST_STREAM;
          end
        end
        ST_STREAM: begin
          if (byte_done) begin
            out_valid <= 1'b1;
            out_data  <= rx_byte;
            state     <= ST_HOLD;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_addr_probe_chk.sv
module spi_addr_probe_chk #(
  parameter int ADDR_MAX = 4,
  parameter int CNT_W    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             spi_cs_n,
  input logic             spi_sclk,
  input logic             det_valid,
  input logic [CNT_W-1:0] det_bytes,
  input logic             probe_err,
  input logic             out_valid,
  input logic [7:0]       out_data,
  input logic             out_ready,
  input logic             byte_done
);
  p_sclk_low_deselected_r2: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  p_width_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    det_valid |-> (det_bytes >= 1 && int'(det_bytes) <= ADDR_MAX));

  p_err_releases_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    probe_err |-> (spi_cs_n && !det_valid));

  p_stream_after_detect_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> det_valid);

  p_stall_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (!spi_sclk && out_valid && $stable(out_data)));

  p_byte_ends_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> !spi_sclk);

  p_cs_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    det_valid |-> !spi_cs_n);
endmodule

bind spi_addr_probe spi_addr_probe_chk #(.ADDR_MAX(ADDR_MAX), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .spi_cs_n (spi_cs_n),
  .spi_sclk (spi_sclk),
  .det_valid(det_valid),
  .det_bytes(det_bytes),
  .probe_err(probe_err),
  .out_valid(out_valid),
  .out_data (out_data),
  .out_ready(out_ready),
  .byte_done(byte_done)
);

// File: tb/spi_addr_probe_tb.sv
module spi_addr_probe_tb;
  localparam int  CLK_P    = 10;
  localparam int  DIV      = 3;
  localparam int  N_STREAM = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       spi_cs_n, spi_sclk, spi_mosi, spi_miso;
  logic       det_valid, probe_err, out_valid, out_ready = 1'b0;
  logic [2:0] det_bytes;
  logic [7:0] out_data;

  int checks = 0;
  int fails  = 0;

  always #(CLK_P/2) clk = ~clk;

  spi_addr_probe #(.CLK_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .det_valid(det_valid), .det_bytes(det_bytes), .probe_err(probe_err),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Memory contents, restated independently; location 0 is never 0xFF.
  function automatic logic [7:0] mem_val(input int i);
    return (i == 0) ? 8'h5A : 8'((i * 29 + 7) & 8'hFF);
  endfunction

  // ---------------- pin-level memory model ----------------
  int         mem_w = 1;      // address bytes; 5 means never answers
  int         pos_cnt = 0;
  logic [7:0] rx_sh = '0;
  logic [7:0] mosi_log[$];
  logic       miso_drv = 1'b1;

  function automatic logic [7:0] slave_byte(input int t);
    return (t >= mem_w + 1) ? mem_val(t - mem_w - 1) : 8'hFF;
  endfunction

  assign spi_miso = spi_cs_n ? 1'b1 : miso_drv;

  always @(negedge spi_cs_n) begin
    pos_cnt  = 0;
    miso_drv = 1'b1;
  end

  always @(posedge spi_sclk) if (!spi_cs_n) begin
    rx_sh = {rx_sh[6:0], spi_mosi};
    pos_cnt++;
    if (pos_cnt % 8 == 0) mosi_log.push_back(rx_sh);
  end

  always @(negedge spi_sclk) if (!spi_cs_n) begin
    logic [7:0] v;
    v = slave_byte(pos_cnt / 8);
    miso_drv = v[7 - (pos_cnt % 8)];
  end

  // ---------------- phase and select monitors ----------------
  realtime t_rise = 0;
  bit      hi_bad = 0;
  bit      cs_bad = 0;

  always @(posedge spi_sclk) t_rise = $realtime;
  always @(negedge spi_sclk)
    if (rst_n && ($realtime - t_rise != realtime'(DIV * CLK_P))) hi_bad = 1;
  always @(negedge clk)
    if (rst_n && det_valid && spi_cs_n) cs_bad = 1;

  // ---------------- scoreboard ----------------
  logic [7:0] exp_q[$];
  int         got = 0;

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6", "unexpected stream byte", out_data, 0);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(out_data == e, "R6", "stream byte", out_data, e);
      end
      got++;
    end
  end

  task automatic push_expected(input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(mem_val(i));
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0; out_ready = 1'b0; start = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    mosi_log.delete(); exp_q.delete();
    got = 0; hi_bad = 0; cs_bad = 0;
  endtask

  task automatic pulse_start();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic run_width(input int w);
    logic [7:0] held;
    bit         stall_ok;
    bit         fill_ok;
    do_reset();
    mem_w = w;
    push_expected(N_STREAM);
    pulse_start();
    while (!(det_valid || probe_err)) @(negedge clk);
    chk(det_valid && !probe_err, "R4", "detect flag", det_valid, 1);
    chk(int'(det_bytes) == w, "R4", "detected width", det_bytes, w);
    // Consumer stall on the first stream byte.
    while (!out_valid) @(negedge clk);
    held = out_data;
    stall_ok = 1;
    repeat (30) begin
      @(negedge clk);
      if (spi_sclk || !out_valid || out_data != held) stall_ok = 0;
    end
    chk(stall_ok, "R7", "stall holds clock and data", held, out_data);
    while (got < N_STREAM) begin
      @(posedge clk); #1 out_ready = ($realtime / CLK_P) % 3 != 0;
    end
    out_ready = 1'b0;
    while (!out_valid) @(negedge clk);
    chk(got == N_STREAM && exp_q.size() == 0, "R6", "stream count", got, N_STREAM);
    chk(mosi_log.size() >= 1 && mosi_log[0] == 8'h03, "R2", "command byte",
        mosi_log.size() ? mosi_log[0] : 0, 8'h03);
    fill_ok = 1;
    for (int i = 1; i < mosi_log.size(); i++) if (mosi_log[i] != 8'h00) fill_ok = 0;
    chk(fill_ok && mosi_log.size() >= w + N_STREAM + 1, "R3", "zero fill bytes",
        mosi_log.size(), w + N_STREAM + 1);
    chk(!hi_bad, "R8", "SCLK high phase length", hi_bad, 0);
    chk(!cs_bad && !spi_cs_n, "R9", "chip select held", spi_cs_n, 0);
  endtask

  task automatic run_absent();
    do_reset();
    mem_w = 5;
    pulse_start();
    while (!(det_valid || probe_err)) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(probe_err == 1'b1, "R5", "error flag", probe_err, 1);
    chk(spi_cs_n == 1'b1 && det_valid == 1'b0, "R5", "select released, no width",
        {spi_cs_n, det_valid}, 2'b10);
    chk(mosi_log.size() == 6, "R5", "bytes sent before giving up", mosi_log.size(), 6);
    chk(out_valid == 1'b0, "R5", "no stream on error", out_valid, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(spi_cs_n && !spi_sclk && !det_valid && !probe_err && !out_valid, "R1",
        "reset outputs", {spi_cs_n, spi_sclk, det_valid, probe_err, out_valid}, 5'b10000);
    rst_n = 1'b1;
    for (int w = 1; w <= 4; w++) run_width(w);
    run_absent();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run hung, actual 0 expected 1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule